// File: doc/BRIEF.md
# Multi-Master Bus Arbiter and Requester

This block sits on a backplane shared by several bus masters and does two jobs. As a requester, it places the local master's bus request on one of two priority request lines, picked by a static strap. As an arbiter, it watches the request lines of every master, local and remote, and drives one grant output per master. Remote requests arrive asynchronously and pass through a synchronizer chain before they reach the decision logic.

Ownership is not preemptive. A master keeps the bus for as long as it asserts its request. The bus is only handed over when the owner drops its request and the address strobe is idle. A lock input freezes the grant so that the owner can run an indivisible series of cycles. A default-master strap parks the bus on the local master when nobody is asking for it. A release-on-request strap keeps the local request up after the local need goes away, until some other master asks for the bus.

Master index 0 is always the local master. Remote master k (k >= 1) drives bit k-1 of the remote request vectors.

Top module: `bus_arbiter_requester`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, every grant output and both local request lines are low.
- R2: The local request appears one clock edge after the local need is sampled high. When the level strap is 0 it appears on `bus_rq0_o` only. When the strap is 1 it appears on `bus_rq1_o` only.
- R3: At a grant decision, any request on level 0 wins over every request on level 1, whatever the master indices are.
- R4: Among requests on the same level, the lowest master index wins. The local master is index 0.
- R5: The current owner keeps its grant for as long as its own request stays asserted, even when requests of higher priority are pending.
- R6: While `strobe_i` is high, the grant outputs do not change on the following edge.
- R7: While `lock_i` is high, the grant outputs do not change on the following edge, and no master is granted if none was granted before.
- R8: When no request is pending and the bus is free, the grant goes to the local master (`gnt_o[0]`) if the default-master strap is 1. If the strap is 0, no grant is asserted.
- R9: When the release-on-request strap is 0, the local request lines drop one edge after the local need is sampled low.
- R10: When the release-on-request strap is 1 and the local master owns the bus, its request stays asserted after the local need drops. It is dropped one edge after a synchronized remote request is seen, and the bus then passes to that requester.
- R11: At most one grant output is high in any cycle.
- R12: A remote request is synchronized through two flops. A grant caused by a remote request appears on the third clock edge after the request is driven, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lvl_i | input | 1 | Strap: request level used by the local master (0 = high priority) |
| cfg_dflt_i | input | 1 | Strap: local master is the default owner of an idle bus |
| cfg_ror_i | input | 1 | Strap: hold the local request until another master asks |
| loc_need_i | input | 1 | Local master needs the bus |
| ext_l0_i | input | N_MST-1 | Asynchronous level-0 requests of remote masters 1..N_MST-1 |
| ext_l1_i | input | N_MST-1 | Asynchronous level-1 requests of remote masters 1..N_MST-1 |
| strobe_i | input | 1 | Address strobe asserted: the current bus cycle is in progress |
| lock_i | input | 1 | Freeze ownership for indivisible cycles |
| bus_rq0_o | output | 1 | Local request driven on level 0 |
| bus_rq1_o | output | 1 | Local request driven on level 1 |
| gnt_o | output | N_MST | One grant per master, bit 0 is the local master |

## Verification
The bench builds the block with its default of four masters and a two-stage synchronizer. This gives three remote masters next to the local one. With three remotes, the bench can place a low-index request on the low-priority level against a high-index request on the high-priority level. It can also check ties between remote and local requests on the same level. Because the synchronizer depth is the default, the bench can check the exact three-edge grant latency for remote requests against the two-edge latency for local ones. It can also line up remote and local requests so that both reach the same decision edge.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Which request line the local master uses.
    typedef enum logic {
        LVL_HI = 1'b0,
        LVL_LO = 1'b1
    } req_lvl_e;

    localparam int unsigned SYNC_DEPTH_DEF = 2;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int unsigned W      = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/arb_requester.sv
module arb_requester
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_lvl_i,
    input  logic cfg_ror_i,
    input  logic loc_need_i,
    input  logic own_gnt_i,
    input  logic other_req_i,
    output logic rq0_o,
    output logic rq1_o
);

    typedef struct packed {
        logic rq0;
        logic rq1;
    } rq_state_t;

    rq_state_t st_d, st_q;
    req_lvl_e  lvl;
    logic      active_q;
    logic      keep;
    logic      want_d;

    assign lvl      = req_lvl_e'(cfg_lvl_i);
    assign active_q = st_q.rq0 | st_q.rq1;

    always_comb begin
        // Keep asking only while owning the bus and nobody else wants it.
        keep   = cfg_ror_i & active_q & own_gnt_i & ~other_req_i;
        want_d = loc_need_i | keep;
        st_d.rq0 = want_d & (lvl == LVL_HI);
        st_d.rq1 = want_d & (lvl == LVL_LO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rq0_o = st_q.rq0;
    assign rq1_o = st_q.rq1;

endmodule

// File: rtl/arb_grant.sv
module arb_grant #(
    parameter int unsigned N_MST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req_l0_i,
    input  logic [N_MST-1:0] req_l1_i,
    input  logic             strobe_i,
    input  logic             lock_i,
    input  logic             dflt_i,
    output logic [N_MST-1:0] gnt_o
);

    localparam logic [N_MST-1:0] LOCAL_ONE = {{(N_MST-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [N_MST-1:0] gnt;
    } gnt_state_t;

    gnt_state_t       st_d, st_q;
    logic             owner_busy;
    logic             frozen;
    logic [N_MST-1:0] pick_l0, pick_l1;

    always_comb begin
        // Lowest set bit of each level wins on that level.
        pick_l0    = req_l0_i & (~req_l0_i + LOCAL_ONE);
        pick_l1    = req_l1_i & (~req_l1_i + LOCAL_ONE);
        owner_busy = |(st_q.gnt & (req_l0_i | req_l1_i));
        frozen     = lock_i | strobe_i | owner_busy;
        st_d       = st_q;
        if (!frozen) begin
            if (|req_l0_i)      st_d.gnt = pick_l0;
            else if (|req_l1_i) st_d.gnt = pick_l1;
            else if (dflt_i)    st_d.gnt = LOCAL_ONE;
            else                st_d.gnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt_o = st_q.gnt;

endmodule

// File: rtl/bus_arbiter_requester.sv
module bus_arbiter_requester
    import arb_pkg::*;
#(
    parameter int unsigned N_MST       = 4,
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_lvl_i,
    input  logic             cfg_dflt_i,
    input  logic             cfg_ror_i,
    input  logic             loc_need_i,
    input  logic [N_MST-2:0] ext_l0_i,
    input  logic [N_MST-2:0] ext_l1_i,
    input  logic             strobe_i,
    input  logic             lock_i,
    output logic             bus_rq0_o,
    output logic             bus_rq1_o,
    output logic [N_MST-1:0] gnt_o
);

    localparam int unsigned N_EXT = N_MST - 1;

    logic [N_EXT-1:0] ext_l0_s, ext_l1_s;
    logic             rq0, rq1;
    logic [N_MST-1:0] gnt;

    arb_sync #(.W(2*N_EXT), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ext_l1_i, ext_l0_i}),
        .sync_o  ({ext_l1_s, ext_l0_s})
    );

    arb_requester u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_lvl_i   (cfg_lvl_i),
        .cfg_ror_i   (cfg_ror_i),
        .loc_need_i  (loc_need_i),
        .own_gnt_i   (gnt[0]),
        .other_req_i (|{ext_l0_s, ext_l1_s}),
        .rq0_o       (rq0),
        .rq1_o       (rq1)
    );

    arb_grant #(.N_MST(N_MST)) u_gnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_l0_i ({ext_l0_s, rq0}),
        .req_l1_i ({ext_l1_s, rq1}),
        .strobe_i (strobe_i),
        .lock_i   (lock_i),
        .dflt_i   (cfg_dflt_i),
        .gnt_o    (gnt)
    );

    assign bus_rq0_o = rq0;
    assign bus_rq1_o = rq1;
    assign gnt_o     = gnt;

endmodule

// File: rtl/bus_arbiter_requester_chk.sv
module bus_arbiter_requester_chk #(
    parameter int unsigned N_MST = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_lvl_i,
    input logic             cfg_ror_i,
    input logic             loc_need_i,
    input logic             strobe_i,
    input logic             lock_i,
    input logic             bus_rq0_o,
    input logic             bus_rq1_o,
    input logic [N_MST-1:0] gnt_o
);

    // R11: grants are one-hot or empty
    a_r11_onehot_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R6: a running bus cycle freezes the grant
    a_r6_strobe_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> $stable(gnt_o));

    // R7: lock freezes the grant
    a_r7_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(gnt_o));

    // R5: a local owner that still requests keeps the bus
    a_r5_owner_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o[0] && (bus_rq0_o || bus_rq1_o)) |=> gnt_o[0]);

    // R2: request on the strapped level only
    a_r2_level_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_need_i && !cfg_lvl_i) |=> (bus_rq0_o && !bus_rq1_o));

    a_r2_level_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_need_i && cfg_lvl_i) |=> (bus_rq1_o && !bus_rq0_o));

    // R9: without release-on-request the request follows the need
    a_r9_follow_need: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_ror_i && !loc_need_i) |=> (!bus_rq0_o && !bus_rq1_o));

endmodule

bind bus_arbiter_requester bus_arbiter_requester_chk #(.N_MST(N_MST)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_lvl_i  (cfg_lvl_i),
    .cfg_ror_i  (cfg_ror_i),
    .loc_need_i (loc_need_i),
    .strobe_i   (strobe_i),
    .lock_i     (lock_i),
    .bus_rq0_o  (bus_rq0_o),
    .bus_rq1_o  (bus_rq1_o),
    .gnt_o      (gnt_o)
);

// File: tb/bus_arbiter_requester_tb_top.sv
module bus_arbiter_requester_tb_top;

    localparam time         CLK_PERIOD = 10ns;
    localparam int unsigned N_MST      = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_lvl, cfg_dflt, cfg_ror, loc_need, strobe, lock;
    logic [N_MST-2:0] ext_l0, ext_l1;
    logic             rq0, rq1;
    logic [N_MST-1:0] gnt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_arbiter_requester #(.N_MST(N_MST)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_lvl_i  (cfg_lvl),
        .cfg_dflt_i (cfg_dflt),
        .cfg_ror_i  (cfg_ror),
        .loc_need_i (loc_need),
        .ext_l0_i   (ext_l0),
        .ext_l1_i   (ext_l1),
        .strobe_i   (strobe),
        .lock_i     (lock),
        .bus_rq0_o  (rq0),
        .bus_rq1_o  (rq1),
        .gnt_o      (gnt)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic lvl, input logic dflt, input logic ror);
        rst_n    = 1'b0;
        cfg_lvl  = lvl;
        cfg_dflt = dflt;
        cfg_ror  = ror;
        loc_need = 1'b0;
        strobe   = 1'b0;
        lock     = 1'b0;
        ext_l0   = '0;
        ext_l1   = '0;
        tick(2);
        chk("R1 gnt in reset", 32'(gnt), 0);
        chk("R1 rq in reset", {30'd0, rq1, rq0}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_and_level();
        do_reset(1'b0, 1'b0, 1'b0);
        tick(1);
        chk("R1 gnt after reset", 32'(gnt), 0);
        loc_need = 1'b1;
        tick(1);
        chk("R2 level0 line", {30'd0, rq1, rq0}, 32'b01);
        tick(1);
        chk("R4 local granted", 32'(gnt), 32'b0001);
        loc_need = 1'b0;
        tick(1);
        chk("R9 request drops", {30'd0, rq1, rq0}, 0);
        tick(1);
        chk("R8 no default grant", 32'(gnt), 0);
        do_reset(1'b1, 1'b0, 1'b0);
        loc_need = 1'b1;
        tick(1);
        chk("R2 level1 line", {30'd0, rq1, rq0}, 32'b10);
    endtask

    task automatic t_default();
        do_reset(1'b0, 1'b1, 1'b0);
        chk("R1 gnt at release", 32'(gnt), 0);
        tick(1);
        chk("R8 parked on local", 32'(gnt), 32'b0001);
        ext_l1[1] = 1'b1;
        tick(3);
        chk("R8 default yields", 32'(gnt), 32'b0100);
    endtask

    task automatic t_priority();
        do_reset(1'b0, 1'b0, 1'b0);
        ext_l1[0] = 1'b1;
        ext_l0[2] = 1'b1;
        tick(2);
        chk("R12 not yet granted", 32'(gnt), 0);
        tick(1);
        chk("R3 level0 beats level1", 32'(gnt), 32'b1000);
        chk("R11 one grant", $countones(gnt), 1);
        do_reset(1'b0, 1'b0, 1'b0);
        ext_l1[0] = 1'b1;
        ext_l1[2] = 1'b1;
        tick(3);
        chk("R4 lowest remote index", 32'(gnt), 32'b0010);
        do_reset(1'b1, 1'b0, 1'b0);
        ext_l1[0] = 1'b1;
        tick(1);
        loc_need = 1'b1;
        tick(2);
        chk("R4 local wins tie", 32'(gnt), 32'b0001);
    endtask

    task automatic t_hold();
        do_reset(1'b0, 1'b0, 1'b0);
        ext_l1[0] = 1'b1;
        tick(3);
        chk("R12 remote granted", 32'(gnt), 32'b0010);
        ext_l0[1] = 1'b1;
        tick(5);
        chk("R5 owner keeps bus", 32'(gnt), 32'b0010);
        ext_l1[0] = 1'b0;
        tick(2);
        chk("R5 handover waits sync", 32'(gnt), 32'b0010);
        tick(1);
        chk("R5 handover", 32'(gnt), 32'b0100);
    endtask

    task automatic t_strobe_lock();
        do_reset(1'b0, 1'b0, 1'b0);
        ext_l1[0] = 1'b1;
        tick(3);
        strobe    = 1'b1;
        ext_l1[0] = 1'b0;
        ext_l0[1] = 1'b1;
        tick(5);
        chk("R6 strobe holds grant", 32'(gnt), 32'b0010);
        strobe = 1'b0;
        tick(1);
        chk("R6 release after strobe", 32'(gnt), 32'b0100);
        do_reset(1'b0, 1'b0, 1'b0);
        ext_l1[0] = 1'b1;
        tick(3);
        lock      = 1'b1;
        ext_l1[0] = 1'b0;
        ext_l0[2] = 1'b1;
        tick(5);
        chk("R7 lock holds grant", 32'(gnt), 32'b0010);
        lock = 1'b0;
        tick(1);
        chk("R7 release after lock", 32'(gnt), 32'b1000);
        do_reset(1'b0, 1'b0, 1'b0);
        lock      = 1'b1;
        ext_l0[0] = 1'b1;
        tick(5);
        chk("R7 no grant under lock", 32'(gnt), 0);
        lock = 1'b0;
        tick(1);
        chk("R7 grant after unlock", 32'(gnt), 32'b0010);
    endtask

    task automatic t_release_on_request();
        do_reset(1'b0, 1'b0, 1'b1);
        loc_need = 1'b1;
        tick(2);
        chk("R10 local owns", 32'(gnt), 32'b0001);
        loc_need = 1'b0;
        tick(4);
        chk("R10 request held", {30'd0, rq1, rq0}, 32'b01);
        chk("R10 bus held", 32'(gnt), 32'b0001);
        ext_l1[2] = 1'b1;
        tick(2);
        chk("R10 held until sync", {30'd0, rq1, rq0}, 32'b01);
        tick(1);
        chk("R10 request released", {30'd0, rq1, rq0}, 0);
        chk("R10 grant still local", 32'(gnt), 32'b0001);
        tick(1);
        chk("R10 bus handed over", 32'(gnt), 32'b1000);
    endtask

    initial begin
        t_reset_and_level();
        t_default();
        t_priority();
        t_hold();
        t_strobe_lock();
        t_release_on_request();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule